// File: doc/BRIEF.md
# Thermal Foldback Gain Controller

This block keeps an audio power stage running when its silicon gets hot. Instead of shutting the amplifier down, it reduces the gain a little at a time. A digital junction-temperature reading arrives with a valid strobe and is compared against a foldback threshold. While the die is above that threshold, an attenuation code for the volume path grows by one 0.5 dB step per update interval. When the die has cooled clearly below the threshold, the code shrinks again one step per interval. The die therefore settles close to the threshold and keeps playing at reduced power.

The threshold defaults to 125 °C. When the control-mode input selects pin control, the threshold stays fixed at that value. When it selects register control, software may lower the threshold through a register field. It can never raise the threshold: a programmed value above the default is clamped to the default. A 2 °C hysteresis band below the threshold freezes the code, so it does not chatter. Separately, the block flags any reading above 160 °C so that downstream logic can force the outputs to tri-state. The block applies no gain itself and performs no shutdown itself.

Top module: `thermfold_ctrl`

## Requirements
- R1: While the latest accepted temperature is strictly above the effective threshold, `atten_code` rises by exactly one code (0.5 dB) per update interval of `STEP_CYCLES` clocks.
- R2: `atten_code` never exceeds `ATT_MAX` (48 by default) and stays there while the temperature stays above the threshold.
- R3: While the temperature is below the effective threshold minus 2 °C, `atten_code` falls by exactly one code per interval and stops at 0.
- R4: While the temperature lies from the threshold minus 2 °C up to and including the threshold, `atten_code` holds its value.
- R5: With `reg_ctrl` = 0, the effective threshold is 125 °C, whatever the value of `reg_thresh`.
- R6: With `reg_ctrl` = 1 and `reg_thresh` below 125, the effective threshold is `reg_thresh`.
- R7: With `reg_ctrl` = 1 and `reg_thresh` above 125, the effective threshold is clamped to 125.
- R8: `hard_trip` is 1 exactly when the latest accepted temperature is above 160 °C. It follows a strobe two clocks later.
- R9: `fold_active` is 1 exactly when `atten_code` is non-zero.
- R10: After reset, `atten_code` = 0, both flags are 0, and the held temperature is 0.
- R11: `temp_data` is accepted only in cycles where `temp_valid` = 1. In other cycles it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_valid | input | 1 | Strobe that qualifies `temp_data` |
| temp_data | input | TEMP_W (9) | Junction temperature in whole °C, unsigned |
| reg_ctrl | input | 1 | 1 = register control, 0 = pin control |
| reg_thresh | input | TEMP_W (9) | Programmed foldback threshold in °C |
| atten_code | output | ATT_W (6) | Attenuation in 0.5 dB codes, 0 = unity gain |
| fold_active | output | 1 | Attenuation is non-zero |
| hard_trip | output | 1 | Latest reading above the hard limit |

## Verification
A wrong held temperature or effective threshold shows up at the ports as the wrong ramp direction: the code rises, falls or holds against expectation. This becomes visible within one update interval, so every check measures the code change over exactly one `STEP_CYCLES` window. A bad interval counter shows up as a change of zero or of two codes in such a window. A stuck ramp register shows up as a missing saturation or floor at the ends of the code range. A corrupted hard-limit path is visible on `hard_trip` two clocks after the strobe.

// File: rtl/thf_pkg.sv
package thf_pkg;
  typedef enum logic [1:0] {
    ZONE_HOLD = 2'd0,
    ZONE_HOT  = 2'd1,
    ZONE_COOL = 2'd2
  } thf_zone_e;
endpackage

// File: rtl/thf_threshold.sv
module thf_threshold #(
  parameter int TEMP_W      = 9,
  parameter int DEFAULT_THR = 125
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_ctrl,
  input  logic [TEMP_W-1:0] reg_thresh,
  output logic [TEMP_W-1:0] thr_eff
);
  localparam logic [TEMP_W-1:0] DEF_T = TEMP_W'(DEFAULT_THR);

  logic [TEMP_W-1:0] thr_sel;

  // Only lowering is allowed; anything above the default is clamped.
  always_comb begin
    thr_sel = DEF_T;
    if (reg_ctrl && (reg_thresh < DEF_T))
      thr_sel = reg_thresh;
  end

  always_ff @(posedge clk) begin
    if (rst) thr_eff <= DEF_T;
    else     thr_eff <= thr_sel;
  end
endmodule

// File: rtl/thf_zone.sv
module thf_zone
  import thf_pkg::*;
#(
  parameter int TEMP_W     = 9,
  parameter int HYST       = 2,
  parameter int HARD_LIMIT = 160
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              temp_valid,
  input  logic [TEMP_W-1:0] temp_data,
  input  logic [TEMP_W-1:0] thr_eff,
  output thf_zone_e         zone,
  output logic              hard_trip
);
  localparam int            EXT_W = TEMP_W + 1;
  localparam logic [EXT_W-1:0] HYST_X = EXT_W'(HYST);
  localparam logic [TEMP_W-1:0] HARD_T = TEMP_W'(HARD_LIMIT);

  logic [TEMP_W-1:0] temp_q;
  logic [EXT_W-1:0]  temp_plus_h;

  always_ff @(posedge clk) begin
    if (rst)             temp_q <= '0;
    else if (temp_valid) temp_q <= temp_data;
  end

  always_ff @(posedge clk) begin
    if (rst) hard_trip <= 1'b0;
    else     hard_trip <= (temp_q > HARD_T);
  end

  // Compare temp + hyst < thr to avoid an underflow of thr - hyst.
  assign temp_plus_h = {1'b0, temp_q} + HYST_X;

  always_comb begin
    if (temp_q > thr_eff)
      zone = ZONE_HOT;
    else if (temp_plus_h < {1'b0, thr_eff})
      zone = ZONE_COOL;
    else
      zone = ZONE_HOLD;
  end
endmodule

// File: rtl/thf_interval.sv
module thf_interval #(
  parameter int STEP_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || tick) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/thf_ramp.sv
module thf_ramp
  import thf_pkg::*;
#(
  parameter int ATT_W   = 6,
  parameter int ATT_MAX = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  thf_zone_e        zone,
  output logic [ATT_W-1:0] atten_code,
  output logic             fold_active
);
  localparam logic [ATT_W-1:0] MAX_C = ATT_W'(ATT_MAX);

  logic [ATT_W-1:0] att_nxt;

  always_comb begin
    att_nxt = atten_code;
    if (tick) begin
      unique case (zone)
        ZONE_HOT:  if (atten_code < MAX_C) att_nxt = atten_code + 1'b1;
        ZONE_COOL: if (atten_code != '0)   att_nxt = atten_code - 1'b1;
        default:   att_nxt = atten_code;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      atten_code  <= '0;
      fold_active <= 1'b0;
    end else begin
      atten_code  <= att_nxt;
      fold_active <= (att_nxt != '0);
    end
  end
endmodule

// File: rtl/thermfold_ctrl.sv
module thermfold_ctrl
  import thf_pkg::*;
#(
  parameter int TEMP_W      = 9,
  parameter int ATT_W       = 6,
  parameter int ATT_MAX     = 48,
  parameter int STEP_CYCLES = 50000,
  parameter int DEFAULT_THR = 125,
  parameter int HARD_LIMIT  = 160,
  parameter int HYST        = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              temp_valid,
  input  logic [TEMP_W-1:0] temp_data,
  input  logic              reg_ctrl,
  input  logic [TEMP_W-1:0] reg_thresh,
  output logic [ATT_W-1:0]  atten_code,
  output logic              fold_active,
  output logic              hard_trip
);
  logic [TEMP_W-1:0] thr_eff;
  thf_zone_e         zone;
  logic              tick;

  thf_threshold #(.TEMP_W(TEMP_W), .DEFAULT_THR(DEFAULT_THR)) u_thr (
    .clk(clk), .rst(rst), .reg_ctrl(reg_ctrl), .reg_thresh(reg_thresh),
    .thr_eff(thr_eff)
  );

  thf_zone #(.TEMP_W(TEMP_W), .HYST(HYST), .HARD_LIMIT(HARD_LIMIT)) u_zone (
    .clk(clk), .rst(rst), .temp_valid(temp_valid), .temp_data(temp_data),
    .thr_eff(thr_eff), .zone(zone), .hard_trip(hard_trip)
  );

  thf_interval #(.STEP_CYCLES(STEP_CYCLES)) u_int (
    .clk(clk), .rst(rst), .tick(tick)
  );

  thf_ramp #(.ATT_W(ATT_W), .ATT_MAX(ATT_MAX)) u_ramp (
    .clk(clk), .rst(rst), .tick(tick), .zone(zone),
    .atten_code(atten_code), .fold_active(fold_active)
  );
endmodule

// File: rtl/thf_checker.sv
module thf_checker #(
  parameter int TEMP_W     = 9,
  parameter int ATT_W      = 6,
  parameter int ATT_MAX    = 48,
  parameter int HARD_LIMIT = 160
) (
  input logic              clk,
  input logic              rst,
  input logic              temp_valid,
  input logic [TEMP_W-1:0] temp_data,
  input logic [ATT_W-1:0]  atten_code,
  input logic              fold_active,
  input logic              hard_trip
);
  localparam logic [ATT_W-1:0]  MAX_C  = ATT_W'(ATT_MAX);
  localparam logic [TEMP_W-1:0] HARD_T = TEMP_W'(HARD_LIMIT);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    atten_code <= MAX_C); // R2

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (atten_code == $past(atten_code)) ||
    (atten_code == $past(atten_code) + 1'b1) ||
    (atten_code == $past(atten_code) - 1'b1)); // R1

  AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
    fold_active == (atten_code != '0)); // R9

  AST_HARD_SET: assert property (@(posedge clk) disable iff (rst)
    (temp_valid && temp_data > HARD_T) ##1 !temp_valid |=> hard_trip); // R8

  AST_HARD_CLR: assert property (@(posedge clk) disable iff (rst)
    (temp_valid && temp_data <= HARD_T) ##1 !temp_valid |=> !hard_trip); // R8
endmodule

bind thermfold_ctrl thf_checker #(
  .TEMP_W(TEMP_W), .ATT_W(ATT_W), .ATT_MAX(ATT_MAX), .HARD_LIMIT(HARD_LIMIT)
) u_chk (
  .clk(clk), .rst(rst), .temp_valid(temp_valid), .temp_data(temp_data),
  .atten_code(atten_code), .fold_active(fold_active), .hard_trip(hard_trip)
);

// File: tb/thermfold_ctrl_test.sv
`timescale 1ns/1ps
module thermfold_ctrl_test;
  localparam int TEMP_W = 9;
  localparam int ATT_W  = 6;
  localparam int AMAX   = 48;
  localparam int STEP   = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              temp_valid = 1'b0;
  logic [TEMP_W-1:0] temp_data = '0;
  logic              reg_ctrl = 1'b0;
  logic [TEMP_W-1:0] reg_thresh = '0;
  logic [ATT_W-1:0]  atten_code;
  logic              fold_active;
  logic              hard_trip;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  thermfold_ctrl #(
    .TEMP_W(TEMP_W), .ATT_W(ATT_W), .ATT_MAX(AMAX), .STEP_CYCLES(STEP)
  ) uut (
    .clk(clk), .rst(rst), .temp_valid(temp_valid), .temp_data(temp_data),
    .reg_ctrl(reg_ctrl), .reg_thresh(reg_thresh),
    .atten_code(atten_code), .fold_active(fold_active), .hard_trip(hard_trip)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_temp(input int t);
    @(negedge clk);
    temp_valid = 1'b1;
    temp_data  = TEMP_W'(t);
    @(negedge clk);
    temp_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Code change across exactly one interval window.
  task automatic delta(output int d);
    int a;
    a = int'(atten_code);
    repeat (STEP) @(negedge clk);
    d = int'(atten_code) - a;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(atten_code == 0, "R10 atten", int'(atten_code), 0);
    check(!fold_active, "R10 fold", int'(fold_active), 0);
    check(!hard_trip, "R10 hard", int'(hard_trip), 0);
  endtask

  task automatic t_legacy_ramp();
    int d;
    reg_ctrl = 1'b0; reg_thresh = TEMP_W'(100);
    set_temp(110);               // below 123 with fixed 125 threshold
    delta(d);
    check(d == 0 && atten_code == 0, "R5 fixed threshold", d, 0);
    set_temp(126);
    delta(d); check(d == 1, "R1 rise", d, 1);
    delta(d); check(d == 1, "R1 rise again", d, 1);
    check(fold_active, "R9 fold on", int'(fold_active), 1);
    set_temp(125);
    delta(d); check(d == 0, "R4 hold at threshold", d, 0);
    set_temp(123);
    delta(d); check(d == 0, "R4 hold at band floor", d, 0);
    set_temp(122);
    delta(d); check(d == -1, "R3 fall", d, -1);
  endtask

  task automatic t_ignore();
    int d;
    @(negedge clk);
    temp_data = TEMP_W'(150);    // no strobe
    repeat (3) @(negedge clk);
    delta(d); check(d == -1, "R11 unstrobed data ignored", d, -1);
    repeat ((AMAX + 2) * STEP) @(negedge clk);
    check(atten_code == 0, "R3 floor", int'(atten_code), 0);
    check(!fold_active, "R9 fold off", int'(fold_active), 0);
  endtask

  task automatic t_reg_lower();
    int d;
    reg_ctrl = 1'b1; reg_thresh = TEMP_W'(100);
    set_temp(110);
    delta(d); check(d == 1, "R6 lowered threshold rise", d, 1);
    set_temp(98);
    delta(d); check(d == 0, "R6 lowered band hold", d, 0);
    set_temp(97);
    delta(d); check(d == -1, "R6 lowered fall", d, -1);
  endtask

  task automatic t_clamp();
    int d;
    reg_ctrl = 1'b1; reg_thresh = TEMP_W'(140);
    set_temp(130);
    delta(d); check(d == 1, "R7 clamp rise", d, 1);
    set_temp(124);
    delta(d); check(d == 0, "R7 clamp band", d, 0);
  endtask

  task automatic t_saturate();
    int d;
    set_temp(150);
    repeat ((AMAX + 2) * STEP) @(negedge clk);
    check(atten_code == AMAX, "R2 saturate", int'(atten_code), AMAX);
    delta(d); check(d == 0, "R2 stays at max", d, 0);
  endtask

  task automatic t_hard();
    set_temp(160);
    check(!hard_trip, "R8 at limit", int'(hard_trip), 0);
    @(negedge clk); temp_valid = 1'b1; temp_data = TEMP_W'(161);
    @(negedge clk); temp_valid = 1'b0;
    check(!hard_trip, "R8 latency early", int'(hard_trip), 0);
    @(negedge clk);
    check(hard_trip, "R8 above limit", int'(hard_trip), 1);
    set_temp(160);
    check(!hard_trip, "R8 clear", int'(hard_trip), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_legacy_ramp();
    t_ignore();
    t_reg_lower();
    t_clamp();
    t_saturate();
    t_hard();
    summary();
  end
endmodule